// File: doc/BRIEF.md
# Framed Link Input Port

This block is the receive half of a full-duplex point-to-point on-chip link. Each link word is 36 bits wide: 32 bits of data and 4 tag bits. The tag bits mark where a packet begins and ends, carry even parity over the data, and carry an error flag. A packet is any number of words. Its first word is the whole header, and that header holds an 8-bit destination terminal number.

Words that arrive are checked for parity and framing, tagged, and written into a four-entry input buffer. The buffer's head is offered to a router core with a valid/ready handshake. Each flit carries its data, its first and last markers, a combined error tag, and the destination of the packet it belongs to.

Flow control is credit based and uses two signals per channel: a word-valid strobe from the sender and a credit-return pulse back to it. The sender starts with four credits, one per buffer entry. It gets one credit back for every word that leaves the buffer.

Top module: `link_rx_port`

## Requirements
- R1: The link word is laid out as follows. Bits 31:0 are data. Bit 32 is begin. Bit 33 is end. Bit 34 is the parity bit. Bit 35 is the error flag. A word offered while the buffer holds fewer than 4 words is accepted, and flits leave in arrival order. `flit_valid_o` is high exactly when the buffer holds at least one word. Each flit's data, `flit_first_o` (its begin bit) and `flit_last_o` (its end bit) are visible from the cycle after the clock edge that accepts the word.
- R2: `head_dest_o` gives the destination of the head flit's packet. For a word with the begin bit set, the destination is its data bits 31:24. Every other word takes the destination of the most recent begin word, or 0 if no begin word has been accepted since reset.
- R3: The buffer holds at most 4 words. A word offered while 4 words are held is discarded, even if a flit leaves in the same cycle. A discarded word is never forwarded, changes no framing state and returns no credit.
- R4: `lnk_credit_o` is high for one cycle in the cycle after each edge on which a flit leaves (`flit_valid_o` and `flit_ready_i` both high), and is low at all other times. The sender starts with 4 credits.
- R5: The parity of a word is correct when the XOR of bits 31:0 and bit 34 is 0. An accepted word with a parity mismatch sets `parity_err_o` from the next cycle, and `parity_err_o` stays set until reset. Such a word is forwarded with `flit_err_o` high.
- R6: Two accepted words are framing violations: a word with the begin bit set while a packet is open, and a word without the begin bit while no packet is open. Either makes `frame_err_o` high for exactly the next cycle, and the word is forwarded with `flit_err_o` high. A begin word always opens a new packet, unless its end bit is also set. An end bit closes the open packet.
- R7: The error flag (bit 35) of an accepted word is passed through to that flit's `flit_err_o`. `flit_err_o` is the OR of this flag with the R5 and R6 conditions.
- R8: While `flit_valid_o` is high and `flit_ready_i` is low, the head flit and all its fields hold unchanged.
- R9: While `rst_n` is low and after its release, the buffer is empty, no credit is returned, `parity_err_o` and `frame_err_o` are low, no packet is open, and the held destination is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnk_valid_i | input | 1 | Sender strobe: a link word is present |
| lnk_word_i | input | 36 | Link word: data plus tag bits |
| lnk_credit_o | output | 1 | One-cycle credit return to the sender |
| flit_valid_o | output | 1 | Head flit available |
| flit_ready_i | input | 1 | Router core takes the head flit |
| flit_data_o | output | 32 | Head flit data |
| flit_first_o | output | 1 | Head flit opens a packet |
| flit_last_o | output | 1 | Head flit closes a packet |
| flit_err_o | output | 1 | Head flit carries an error |
| head_dest_o | output | 8 | Destination terminal of the head flit's packet |
| parity_err_o | output | 1 | Sticky parity-mismatch indicator |
| frame_err_o | output | 1 | One-cycle framing-violation pulse |

## Verification
An accepted word reaches the flit outputs one edge after it is accepted. The framing pulse and the parity flag appear on that same edge. A credit pulse appears one edge after the flit leaves. The bench drives and samples only on falling clock edges. At each falling edge it first compares every output against a model that is advanced by one edge per step, and only then applies the next inputs and updates the model. Every result is therefore checked exactly one edge after its cause. Directed cases cover overflow, the two framing violations, a single-word packet, and reset in mid-traffic. A long constrained-random run follows, with a sender that keeps to its credits.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;

  localparam int DATA_W = 32;
  localparam int DEST_W = 8;
  localparam int TAG_W  = 4;
  localparam int WORD_W = DATA_W + TAG_W;

  // tag bit positions; the sender encodes words with these
  localparam int TAG_BEGIN = DATA_W;
  localparam int TAG_END   = DATA_W + 1;
  localparam int TAG_PAR   = DATA_W + 2;
  localparam int TAG_ERR   = DATA_W + 3;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              first;
    logic              last;
    logic              err;
    logic [DATA_W-1:0] data;
  } flit_t;

  localparam int FLIT_W = $bits(flit_t);

  function automatic logic data_parity(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

endpackage

// File: rtl/link_rx_frame.sv
module link_rx_frame
  import link_rx_pkg::*;
#(
  parameter int DEST_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [WORD_W-1:0] word_i,
  output flit_t             flit_o,
  output logic              frame_err_o,
  output logic              parity_err_o
);

  logic [DATA_W-1:0] data_w;
  logic              begin_w, end_w, par_w, errtag_w;
  logic              par_bad, frame_bad;

  logic              open_q, open_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic              frame_q, frame_d;
  logic              sticky_q, sticky_d;

  assign data_w   = word_i[DATA_W-1:0];
  assign begin_w  = word_i[TAG_BEGIN];
  assign end_w    = word_i[TAG_END];
  assign par_w    = word_i[TAG_PAR];
  assign errtag_w = word_i[TAG_ERR];

  assign par_bad   = data_parity(data_w) != par_w;
  assign frame_bad = begin_w ? open_q : !open_q;

  always_comb begin
    flit_o.data  = data_w;
    flit_o.first = begin_w;
    flit_o.last  = end_w;
    flit_o.err   = errtag_w | par_bad | frame_bad;
    flit_o.dest  = begin_w ? data_w[DEST_LSB +: DEST_W] : dest_q;
  end

  // next state
  always_comb begin
    open_d   = open_q;
    dest_d   = dest_q;
    frame_d  = 1'b0;
    sticky_d = sticky_q;
    if (acc_i) begin
      frame_d  = frame_bad;
      sticky_d = sticky_q | par_bad;
      if (begin_w) begin
        open_d = !end_w;
        dest_d = data_w[DEST_LSB +: DEST_W];
      end else if (end_w) begin
        open_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      dest_q   <= '0;
      frame_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      open_q   <= open_d;
      dest_q   <= dest_d;
      frame_q  <= frame_d;
      sticky_q <= sticky_d;
    end
  end

  assign frame_err_o  = frame_q;
  assign parity_err_o = sticky_q;

endmodule

// File: rtl/link_rx_fifo.sv
module link_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  input  logic         rd_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;
  logic [W-1:0]  slot_view [DEPTH];

  assign full_o  = cnt_q == CW'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_en;
    assign slot_en = do_wr && (wr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= din_i;
    end
    assign slot_view[i] = slot_q;
  end

  assign dout_o = slot_view[rd_q];

  always_comb begin
    wr_d  = do_wr ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_rd ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_wr && !do_rd) cnt_d = cnt_q + CW'(1);
    else if (!do_wr && do_rd) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/link_rx_credit.sv
module link_rx_credit (
  input  logic clk,
  input  logic rst_n,
  input  logic pop_i,
  output logic credit_o
);

  logic credit_q, credit_d;

  assign credit_d = pop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit_q <= 1'b0;
    else        credit_q <= credit_d;
  end

  assign credit_o = credit_q;

endmodule

// File: rtl/link_rx_port.sv
module link_rx_port
  import link_rx_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int DEST_LSB = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lnk_valid_i,
  input  logic [35:0] lnk_word_i,
  output logic        lnk_credit_o,
  output logic        flit_valid_o,
  input  logic        flit_ready_i,
  output logic [31:0] flit_data_o,
  output logic        flit_first_o,
  output logic        flit_last_o,
  output logic        flit_err_o,
  output logic [7:0]  head_dest_o,
  output logic        parity_err_o,
  output logic        frame_err_o
);

  logic  wr_en, rd_en, full, empty;
  flit_t in_flit, head_flit;

  assign wr_en        = lnk_valid_i && !full;
  assign flit_valid_o = !empty;
  assign rd_en        = flit_valid_o && flit_ready_i;

  link_rx_frame #(.DEST_LSB(DEST_LSB)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_i        (wr_en),
    .word_i       (lnk_word_i),
    .flit_o       (in_flit),
    .frame_err_o  (frame_err_o),
    .parity_err_o (parity_err_o)
  );

  link_rx_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_en),
    .din_i   (in_flit),
    .rd_i    (rd_en),
    .dout_o  (head_flit),
    .full_o  (full),
    .empty_o (empty)
  );

  link_rx_credit u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_i    (rd_en),
    .credit_o (lnk_credit_o)
  );

  assign flit_data_o  = head_flit.data;
  assign flit_first_o = head_flit.first;
  assign flit_last_o  = head_flit.last;
  assign flit_err_o   = head_flit.err;
  assign head_dest_o  = head_flit.dest;

endmodule

// File: rtl/link_rx_port_sva.sv
module link_rx_port_sva #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lnk_valid_i,
  input logic [35:0] lnk_word_i,
  input logic        wr_en,
  input logic        rd_en,
  input logic        lnk_credit_o,
  input logic        flit_valid_o,
  input logic        flit_ready_i,
  input logic [31:0] flit_data_o,
  input logic        flit_first_o,
  input logic        flit_last_o,
  input logic        flit_err_o,
  input logic [7:0]  head_dest_o,
  input logic        parity_err_o
);

  localparam int OW = $clog2(DEPTH + 2) + 1;

  logic [OW-1:0] occ_q, owed_q;

  // own occupancy and unreturned-credit tallies
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      owed_q <= '0;
    end else begin
      occ_q  <= occ_q + OW'(wr_en) - OW'(rd_en);
      owed_q <= owed_q + OW'(wr_en) - OW'(lnk_credit_o);
    end
  end

  p_occupancy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OW'(DEPTH)) |-> !wr_en);

  p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid_o == (occ_q != '0));

  p_credit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(DEPTH));

  p_credit_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_credit_o |-> $past(rd_en));

  p_parity_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_valid_i && wr_en && (^{lnk_word_i[34], lnk_word_i[31:0]})) |=> parity_err_o);

  p_parity_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err_o |=> parity_err_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid_o && !flit_ready_i) |=>
      (flit_valid_o && $stable(flit_data_o) && $stable(flit_first_o) &&
       $stable(flit_last_o) && $stable(flit_err_o) && $stable(head_dest_o)));

endmodule

bind link_rx_port link_rx_port_sva #(.DEPTH(DEPTH)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .lnk_valid_i  (lnk_valid_i),
  .lnk_word_i   (lnk_word_i),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .lnk_credit_o (lnk_credit_o),
  .flit_valid_o (flit_valid_o),
  .flit_ready_i (flit_ready_i),
  .flit_data_o  (flit_data_o),
  .flit_first_o (flit_first_o),
  .flit_last_o  (flit_last_o),
  .flit_err_o   (flit_err_o),
  .head_dest_o  (head_dest_o),
  .parity_err_o (parity_err_o)
);

// File: tb/link_rx_port_tb.sv
module link_rx_port_tb;
  import link_rx_pkg::*;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lnk_valid_i = 1'b0;
  logic [35:0] lnk_word_i = '0;
  logic        flit_ready_i = 1'b0;
  logic        lnk_credit_o, flit_valid_o, flit_first_o, flit_last_o, flit_err_o;
  logic        parity_err_o, frame_err_o;
  logic [31:0] flit_data_o;
  logic [7:0]  head_dest_o;

  always #5 clk = ~clk;

  link_rx_port u_dut (
    .clk(clk), .rst_n(rst_n), .lnk_valid_i(lnk_valid_i), .lnk_word_i(lnk_word_i),
    .lnk_credit_o(lnk_credit_o), .flit_valid_o(flit_valid_o), .flit_ready_i(flit_ready_i),
    .flit_data_o(flit_data_o), .flit_first_o(flit_first_o), .flit_last_o(flit_last_o),
    .flit_err_o(flit_err_o), .head_dest_o(head_dest_o), .parity_err_o(parity_err_o),
    .frame_err_o(frame_err_o)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference model state
  flit_t      m_q[$];
  bit         m_open, m_credit, m_frame, m_sticky;
  logic [7:0] m_dest;
  int         credits, drops, credit_seen;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] mk_word(input logic [31:0] d, input bit b, input bit e,
                                          input bit er, input bit badpar);
    return {er, (^d) ^ badpar, e, b, d};
  endfunction

  task automatic model_reset();
    m_q.delete();
    m_open = 0; m_credit = 0; m_frame = 0; m_sticky = 0; m_dest = '0;
    credits = DEPTH;
  endtask

  // one clock: check outputs left by the previous edge, then drive and advance model
  task automatic step(input bit snd, input logic [35:0] w, input bit rdy);
    bit acc, pop, fr, pb, b, e;
    flit_t f;
    @(negedge clk);
    chk(flit_valid_o == (m_q.size() != 0), "R1 valid", flit_valid_o, m_q.size() != 0);
    chk(lnk_credit_o == m_credit, "R4 credit", lnk_credit_o, m_credit);
    chk(frame_err_o == m_frame, "R6 frame pulse", frame_err_o, m_frame);
    chk(parity_err_o == m_sticky, "R5 parity sticky", parity_err_o, m_sticky);
    if (m_q.size() != 0) begin
      f = m_q[0];
      chk(flit_data_o == f.data, "R1 data", flit_data_o, f.data);
      chk({flit_first_o, flit_last_o} == {f.first, f.last}, "R1 first/last",
          {flit_first_o, flit_last_o}, {f.first, f.last});
      chk(flit_err_o == f.err, "R7 err tag", flit_err_o, f.err);
      chk(head_dest_o == f.dest, "R2 dest", head_dest_o, f.dest);
    end
    if (lnk_credit_o) begin credits++; credit_seen++; end
    acc = snd && (m_q.size() < DEPTH);
    pop = rdy && (m_q.size() != 0);
    lnk_valid_i  = snd;
    lnk_word_i   = w;
    flit_ready_i = rdy;
    if (snd) credits--;
    if (snd && !acc) drops++;
    m_credit = pop;
    if (pop) void'(m_q.pop_front());
    m_frame = 1'b0;
    if (acc) begin
      b  = w[32];
      e  = w[33];
      pb = ((^w[31:0]) != w[34]);
      fr = b ? m_open : !m_open;
      f.data  = w[31:0];
      f.first = b;
      f.last  = e;
      f.err   = w[35] | pb | fr;
      f.dest  = b ? w[31:24] : m_dest;
      m_q.push_back(f);
      if (b) begin m_dest = w[31:24]; m_open = !e; end
      else if (e) m_open = 0;
      m_frame  = fr;
      m_sticky = m_sticky | pb;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lnk_valid_i = 0; flit_ready_i = 0;
    @(negedge clk);
    // R9: outputs cleared while in reset
    chk(!flit_valid_o && !lnk_credit_o && !parity_err_o && !frame_err_o, "R9 reset outputs",
        {flit_valid_o, lnk_credit_o, parity_err_o, frame_err_o}, 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(0, '0, 1);
  endtask

  initial begin
    int seed;
    bit gopen;
    seed = 32'h5A17;
    void'($urandom(seed));
    model_reset();
    drops = 0; credit_seen = 0;
    do_reset();

    // R2/R1: single-word packet (begin and end together), then a three-word packet
    step(1, mk_word(32'hA512_3456, 1, 1, 0, 0), 1);
    step(1, mk_word(32'h3C00_0001, 1, 0, 0, 0), 1);
    step(1, mk_word(32'h1111_2222, 0, 0, 0, 0), 0);
    step(1, mk_word(32'h3333_4444, 0, 1, 0, 0), 0);  // R8 hold while not ready
    drain();
    // R6: data word outside a packet, then begin while open
    step(1, mk_word(32'h0000_00FF, 0, 0, 0, 0), 1);
    step(1, mk_word(32'h7700_0000, 1, 0, 0, 0), 1);
    step(1, mk_word(32'h6600_0000, 1, 0, 0, 0), 1);
    step(1, mk_word(32'h0000_0000, 0, 1, 0, 0), 1);
    // R7: error tag passthrough
    step(1, mk_word(32'h1200_0000, 1, 1, 1, 0), 1);
    drain();
    chk(frame_err_o == 1'b0, "R6 pulse one cycle", frame_err_o, 0);

    // R3: overflow with ready low; the fifth word is dropped
    drops = 0; credit_seen = 0;
    for (int i = 0; i < 5; i++) step(1, mk_word(32'h4400_0000 + i, i == 0, 0, 0, 0), 0);
    step(1, mk_word(32'h9999_9999, 0, 1, 0, 0), 1);  // still full: dropped despite pop
    drain();
    chk(drops == 2, "R3 drop count", drops, 2);
    chk(credit_seen == 4, "R4 credits per flit", credit_seen, 4);
    credits = DEPTH;

    // R5: parity mismatch, then reset clears the sticky flag (R9)
    step(1, mk_word(32'h2100_0000, 1, 0, 0, 1), 1);
    step(1, mk_word(32'h0000_0005, 0, 1, 0, 0), 1);
    drain();
    chk(parity_err_o == 1'b1, "R5 sticky hold", parity_err_o, 1);
    do_reset();
    step(1, mk_word(32'h0000_1234, 0, 0, 0, 0), 1);  // R9: no packet open after reset, dest 0
    drain();

    // random traffic within credits
    gopen = 0;
    for (int n = 0; n < 4000; n++) begin
      bit snd, b, e, er, bp;
      logic [31:0] d;
      int r;
      snd = (credits > 0) && ($urandom_range(0, 99) < 65);
      d = $urandom();
      b = !gopen; e = gopen ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 4) == 0);
      r = $urandom_range(0, 99);
      if (r < 4) b = !b;
      er = (r >= 4 && r < 7);
      bp = (r >= 7 && r < 11);
      if (snd) begin
        if (b) gopen = !e; else if (e) gopen = 0;
      end
      step(snd, mk_word(d, b, e, er, bp), $urandom_range(0, 99) < 70);
      if (credits < 0) begin
        chk(0, "R4 sender credits", credits, 0);
        credits = 0;
      end
    end
    drain();
    chk(credits == DEPTH, "R4 all credits back", credits, DEPTH);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule